// File: doc/BRIEF.md
# Downconverter Sample Ingress Stage

This block is the first stage of a multichannel digital downconverter. Each clock it takes a 16-bit sample from one of four parallel input buses, or from a test word written over a small configuration port. It qualifies that sample with an active-low input enable, optionally extracts one channel out of a time-multiplexed stream, and converts the sample to signed 16-bit fixed point. The result leaves on `smp_o` with a one-cycle `vld_o` strobe.

There are two enable modes:
- **Gated mode:** only the clocks with the enable asserted carry samples.
- **Zero-stuffing interpolated mode:** every clock carries a sample, and the clocks without an enable carry zero. This raises the rate to the clock rate.

No input is accepted until the first pulse on `sync_i`.

For channel extraction, the enable marks channel 0 of a frame. The enable is delayed by the programmed slot number to capture one channel. A second register, loaded by the undelayed enable, realigns the result so that every slot choice produces output at the same frame position.

Top module: `ddc_ingress`

## Requirements
- R1: While `rst_ni` is low, and until the first valid strobe afterwards, `smp_o` is 0 and `vld_o` is 0. The reset configuration is as follows:
  - source bus A;
  - gated mode;
  - slot delay 0;
  - two's complement format;
  - float mode 0;
  - test word 0.
- R2: Before the first clock edge with `sync_i` high, no sample is processed and `vld_o` stays 0. The enable is honoured from the edge after that sync edge onward.
- R3: The configuration port writes on a rising edge with `cfg_we_i` high. The fields are:
  - addr 0: source, bits [2:0]. Values 0 to 3 pick buses A to D; values 4 to 7 pick the test word.
  - addr 1: mode, bit 0. 0 is gated, 1 is interpolated.
  - addr 2: slot delay, bits [2:0].
  - addr 3: format, bits [1:0]. 0 is two's complement, 1 is offset binary, 2 is float, 3 behaves as 0.
  - addr 4: float mode, bits [2:0].
  - addr 5: test word, bits [15:0].
  - Addresses 6 and 7 are ignored.
- R4: In gated mode a processing edge is a rising edge with the enable low. A sample is captured on the edge where the delayed enable is active. It is moved to the realignment register on the next processing edge. It appears on `smp_o`, with `vld_o` high, one clock after that edge.
- R5: In interpolated mode, once synced, every edge is a processing edge and `vld_o` is high every clock. The captured sample is the selected input when the delayed enable is active, and zero otherwise.
- R6: With slot delay N, the captured sample is the one present N clocks after the enable edge. The frame length must exceed N.
- R7: Two's complement passes the word unchanged. Offset binary inverts bit 15.
- R8: In float mode 0, bits [1:0] are an exponent e. The result is the word with bits [1:0] cleared, arithmetically shifted right by e.
- R9: In float modes 1 to 4, bits [2:0] are an exponent e and bits [2:0] are cleared before shifting. The shift is min(e, S), where S is 4, 5, 6 and 7 for modes 1, 2, 3 and 4. Modes 5 to 7 behave as mode 4.
- R10: `smp_o` changes only in a cycle where `vld_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_a_i | input | 16 | Parallel input bus A |
| bus_b_i | input | 16 | Parallel input bus B |
| bus_c_i | input | 16 | Parallel input bus C |
| bus_d_i | input | 16 | Parallel input bus D |
| en_ni | input | 1 | Input enable, active low |
| sync_i | input | 1 | Sync; the first pulse arms the input |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration address |
| cfg_wdata_i | input | 16 | Configuration write data |
| smp_o | output | 16 | Converted signed sample |
| vld_o | output | 1 | Sample valid strobe |

## Verification
The timing of a result follows from when the sample is processed:
- A configuration write takes effect from the following edge.
- A sync edge arms the enable for the next edge.
- A captured sample reaches `smp_o` one clock after the next processing edge. In a continuous gated stream this is two clocks after its own edge. In a multiplexed frame it falls in the first cycle after the next frame's enable edge.

The bench keeps a clock-edge model of those rules and compares both outputs at every falling edge. Each comparison therefore looks at the value settled by the last rising edge.

// File: rtl/ingress_pkg.sv
package ingress_pkg;
  localparam int SAMPLE_W = 16;
  localparam int NBUS     = 4;
  localparam int MAX_CH   = 8;
  localparam int SRC_W    = 3;
  localparam int DLY_W    = $clog2(MAX_CH);
  localparam int FPM_W    = 3;
  localparam int ADDR_W   = 3;

  typedef enum logic [1:0] {
    FMT_TWOS   = 2'd0,
    FMT_OFFSET = 2'd1,
    FMT_FLOAT  = 2'd2,
    FMT_RSVD   = 2'd3
  } fmt_e;

  typedef enum logic [ADDR_W-1:0] {
    A_SRC  = 3'd0,
    A_MODE = 3'd1,
    A_DLY  = 3'd2,
    A_FMT  = 3'd3,
    A_FPM  = 3'd4,
    A_TEST = 3'd5
  } cfg_addr_e;

  typedef struct packed {
    logic [SRC_W-1:0]    src;
    logic                interp;
    logic [DLY_W-1:0]    dly;
    fmt_e                fmt;
    logic [FPM_W-1:0]    fp_mode;
    logic [SAMPLE_W-1:0] test_word;
  } cfg_t;
endpackage

// File: rtl/ingress_cfg.sv
module ingress_cfg
  import ingress_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [SAMPLE_W-1:0] wdata_i,
  output cfg_t                cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_SRC:  cfg_q.src       <= wdata_i[SRC_W-1:0];
        A_MODE: cfg_q.interp    <= wdata_i[0];
        A_DLY:  cfg_q.dly       <= wdata_i[DLY_W-1:0];
        A_FMT:  cfg_q.fmt       <= fmt_e'(wdata_i[1:0]);
        A_FPM:  cfg_q.fp_mode   <= wdata_i[FPM_W-1:0];
        A_TEST: cfg_q.test_word <= wdata_i;
        default: ;
      endcase
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/ingress_srcmux.sv
module ingress_srcmux
  import ingress_pkg::*;
#(
  parameter int N  = NBUS,
  parameter int DW = SAMPLE_W
) (
  input  logic [N-1:0][DW-1:0] bus_i,
  input  logic [DW-1:0]        test_i,
  input  logic [SRC_W-1:0]     sel_i,
  output logic [DW-1:0]        data_o
);
  localparam int IW = $clog2(N);

  always_comb begin
    data_o = test_i;
    for (int k = 0; k < N; k++) begin
      if (sel_i == SRC_W'(k)) data_o = bus_i[k];
    end
  end

  logic unused_iw;
  assign unused_iw = (IW > 0);
endmodule

// File: rtl/ingress_tdm.sv
module ingress_tdm
  import ingress_pkg::*;
#(
  parameter int DW = SAMPLE_W,
  parameter int CH = MAX_CH,
  localparam int DW_L = $clog2(CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sync_i,
  input  logic            en_ni,
  input  logic            interp_i,
  input  logic [DW_L-1:0] dly_i,
  input  logic [DW-1:0]   data_i,
  output logic [DW-1:0]   algn_o,
  output logic            ld_o
);
  logic          armed_q;
  logic          en_act;
  logic [CH-1:1] dq;
  logic [CH-1:0] taps;
  logic          tap;
  logic          cap, realign;
  logic [DW-1:0] sel_d, sel_q, algn_q;
  logic          ld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else if (sync_i) armed_q <= 1'b1;
  end

  assign en_act = armed_q & ~en_ni;

  // enable delay line, one tap per TDM slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dq[1] <= 1'b0;
    else dq[1] <= en_act;
  end

  for (genvar i = 2; i < CH; i++) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dq[i] <= 1'b0;
      else dq[i] <= dq[i-1];
    end
  end

  assign taps    = {dq, en_act};
  assign tap     = taps[dly_i];
  assign cap     = interp_i ? armed_q : tap;
  assign realign = interp_i ? armed_q : en_act;
  assign sel_d   = (interp_i && !tap) ? '0 : data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      algn_q <= '0;
      ld_q   <= 1'b0;
    end else begin
      if (cap) sel_q <= sel_d;
      if (realign) algn_q <= sel_q;
      ld_q <= realign;
    end
  end

  assign algn_o = algn_q;
  assign ld_o   = ld_q;
endmodule

// File: rtl/ingress_fmt.sv
module ingress_fmt
  import ingress_pkg::*;
#(
  parameter int DW = SAMPLE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DW-1:0]    din_i,
  input  logic             ld_i,
  input  fmt_e             fmt_i,
  input  logic [FPM_W-1:0] fpm_i,
  output logic [DW-1:0]    smp_o,
  output logic             vld_o
);
  logic [DW-1:0] mant, conv;
  logic [2:0]    e, sat, sh;

  always_comb begin
    if (fpm_i == '0) begin
      mant = {din_i[DW-1:2], 2'b00};
      e    = {1'b0, din_i[1:0]};
      sat  = 3'd3;
    end else begin
      mant = {din_i[DW-1:3], 3'b000};
      e    = din_i[2:0];
      sat  = (fpm_i >= 3'd4) ? 3'd7 : fpm_i[2:0] + 3'd3;
    end
    sh = (e > sat) ? sat : e;
    unique case (fmt_i)
      FMT_OFFSET: conv = {~din_i[DW-1], din_i[DW-2:0]};
      FMT_FLOAT:  conv = $signed(mant) >>> sh;
      default:    conv = din_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_o <= '0;
      vld_o <= 1'b0;
    end else begin
      if (ld_i) smp_o <= conv;
      vld_o <= ld_i;
    end
  end
endmodule

// File: rtl/ddc_ingress.sv
module ddc_ingress
  import ingress_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] bus_a_i,
  input  logic [SAMPLE_W-1:0] bus_b_i,
  input  logic [SAMPLE_W-1:0] bus_c_i,
  input  logic [SAMPLE_W-1:0] bus_d_i,
  input  logic                en_ni,
  input  logic                sync_i,
  input  logic                cfg_we_i,
  input  logic [ADDR_W-1:0]   cfg_addr_i,
  input  logic [SAMPLE_W-1:0] cfg_wdata_i,
  output logic [SAMPLE_W-1:0] smp_o,
  output logic                vld_o
);
  cfg_t                          cfg_q;
  logic [NBUS-1:0][SAMPLE_W-1:0] buses;
  logic [SAMPLE_W-1:0]           src_data, algn;
  logic                          ld;

  assign buses = {bus_d_i, bus_c_i, bus_b_i, bus_a_i};

  ingress_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg_q)
  );

  ingress_srcmux #(.N(NBUS), .DW(SAMPLE_W)) u_mux (
    .bus_i  (buses),
    .test_i (cfg_q.test_word),
    .sel_i  (cfg_q.src),
    .data_o (src_data)
  );

  ingress_tdm #(.DW(SAMPLE_W), .CH(MAX_CH)) u_tdm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sync_i   (sync_i),
    .en_ni    (en_ni),
    .interp_i (cfg_q.interp),
    .dly_i    (cfg_q.dly),
    .data_i   (src_data),
    .algn_o   (algn),
    .ld_o     (ld)
  );

  ingress_fmt #(.DW(SAMPLE_W)) u_fmt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_i  (algn),
    .ld_i   (ld),
    .fmt_i  (cfg_q.fmt),
    .fpm_i  (cfg_q.fp_mode),
    .smp_o  (smp_o),
    .vld_o  (vld_o)
  );
endmodule

// File: rtl/ddc_ingress_chk.sv
module ddc_ingress_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en_ni,
  input logic        sync_i,
  input logic        interp_i,
  input logic [15:0] smp_o,
  input logic        vld_o
);
  logic seen_q, arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else if (sync_i) seen_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_q <= 1'b0;
    else arm_q <= seen_q;
  end

  a_r2_quiet_before_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> !vld_o);

  a_r4_valid_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && !interp_i && $past(!interp_i) && $past(!interp_i, 2)) |-> $past(!en_ni, 2));

  a_r5_interp_every_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (interp_i && $past(interp_i) && $past(interp_i, 2) && arm_q && $past(arm_q)) |-> vld_o);

  a_r10_hold_without_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> $stable(smp_o));

  a_r1_reset_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!vld_o && smp_o == 16'h0));
endmodule

bind ddc_ingress ddc_ingress_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_ni    (en_ni),
  .sync_i   (sync_i),
  .interp_i (cfg_q.interp),
  .smp_o    (smp_o),
  .vld_o    (vld_o)
);

// File: tb/sim_ddc_ingress.sv
`timescale 1ns/1ps
module sim_ddc_ingress;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] bus_a_i = '0, bus_b_i = '0, bus_c_i = '0, bus_d_i = '0;
  logic        en_ni = 1'b1, sync_i = 1'b0, cfg_we_i = 1'b0;
  logic [2:0]  cfg_addr_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic [15:0] smp_o;
  logic        vld_o;

  always #2 clk_i = ~clk_i;

  ddc_ingress u0 (.*);

  int    n_vec = 0, n_bad = 0;
  string tag = "R1";
  int    gen = 0;
  int    cnt = 0;
  bit    finished = 0;

  // reference state
  logic [2:0]  m_src, m_dly, m_fpm;
  logic        m_interp, m_armed, m_ld, m_vld;
  logic [1:0]  m_fmt;
  logic [15:0] m_test, m_sel, m_align, m_smp;
  logic [7:0]  m_hist;

  function automatic logic [15:0] ref_fmt(input logic [1:0] f, input logic [2:0] fm,
                                          input logic [15:0] x);
    int eb, e, s, sh, m, v, d, r;
    if (f == 2'd1) return x ^ 16'h8000;
    if (f != 2'd2) return x;
    eb = (fm == 0) ? 2 : 3;
    e  = int'(x) & ((1 << eb) - 1);
    s  = (fm == 0) ? 3 : (fm <= 3 ? int'(fm) + 3 : 7);
    sh = (e > s) ? s : e;
    m  = int'($signed(x)) >>> eb;
    v  = m * (1 << eb);
    d  = 1 << sh;
    r  = (v >= 0) ? v / d : -((-v + d - 1) / d);
    return 16'(r);
  endfunction

  function automatic logic [15:0] ref_src();
    case (m_src)
      3'd0: return bus_a_i;
      3'd1: return bus_b_i;
      3'd2: return bus_c_i;
      3'd3: return bus_d_i;
      default: return m_test;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_src = 0; m_dly = 0; m_fpm = 0; m_interp = 0; m_fmt = 0; m_test = 0;
      m_armed = 0; m_ld = 0; m_vld = 0; m_sel = 0; m_align = 0; m_smp = 0; m_hist = 0;
    end else begin
      logic ea, tp, capture, realign;
      logic [15:0] sd;
      ea      = m_armed && !en_ni;
      tp      = (m_dly == 0) ? ea : m_hist[m_dly];
      capture = m_interp ? m_armed : tp;
      realign = m_interp ? m_armed : ea;
      sd      = (m_interp && !tp) ? 16'h0 : ref_src();
      if (m_ld) m_smp = ref_fmt(m_fmt, m_fpm, m_align);
      m_vld = m_ld;
      if (realign) m_align = m_sel;
      m_ld = realign;
      if (capture) m_sel = sd;
      m_hist = {m_hist[6:1], ea, 1'b0};
      if (sync_i) m_armed = 1;
      if (cfg_we_i) begin
        case (cfg_addr_i)
          3'd0: m_src = cfg_wdata_i[2:0];
          3'd1: m_interp = cfg_wdata_i[0];
          3'd2: m_dly = cfg_wdata_i[2:0];
          3'd3: m_fmt = cfg_wdata_i[1:0];
          3'd4: m_fpm = cfg_wdata_i[2:0];
          3'd5: m_test = cfg_wdata_i;
          default: ;
        endcase
      end
    end
  end

  task automatic check();
    n_vec++;
    if (smp_o !== m_smp || vld_o !== m_vld) begin
      n_bad++;
      $display("FAIL %s smp=%h exp=%h vld=%b exp=%b", tag, smp_o, m_smp, vld_o, m_vld);
    end
  endtask

  // one clock: check settled outputs, then drive next inputs
  task automatic cyc(input logic en_n, input logic sy);
    @(negedge clk_i);
    check();
    cnt++;
    en_ni = en_n; sync_i = sy; cfg_we_i = 0;
    if (gen == 0) begin
      bus_a_i = 16'(cnt * 40503 + 17);
      bus_b_i = 16'(cnt * 9973 + 4097);
      bus_c_i = 16'(cnt * 31 + 16'h8000);
      bus_d_i = 16'(cnt * 27361 + 999);
    end else begin
      logic [15:0] v;
      v = {13'(cnt * 997), 3'(cnt)};
      bus_a_i = v; bus_b_i = ~v; bus_c_i = v ^ 16'h5A5A; bus_d_i = v + 16'd3;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk_i);
    check();
    en_ni = 1; sync_i = 0; cfg_we_i = 1; cfg_addr_i = a; cfg_wdata_i = d;
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog expired");
    if (!finished) begin
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk_i);
    if (smp_o !== 16'h0 || vld_o !== 1'b0) begin
      n_bad++; $display("FAIL R1 reset smp=%h exp=0000 vld=%b exp=0", smp_o, vld_o);
    end
    n_vec++;
    rst_ni = 1;
    repeat (4) cyc(1, 0);

    tag = "R2";
    repeat (12) cyc(0, 0);
    cyc(0, 1);
    repeat (10) cyc(0, 0);

    tag = "R3";
    for (int s = 0; s < 8; s++) begin
      wr(3'd0, 16'(s));
      if (s == 4) wr(3'd5, 16'hC3A5);
      if (s == 6) wr(3'd6, 16'h0007);
      repeat (12) cyc(0, 0);
    end
    wr(3'd0, 16'd0);

    tag = "R7";
    wr(3'd3, 16'd1);
    repeat (24) cyc(0, 0);
    wr(3'd3, 16'd3);
    repeat (12) cyc(0, 0);
    wr(3'd3, 16'd0);
    repeat (12) cyc(0, 0);

    gen = 1;
    wr(3'd3, 16'd2);
    for (int fm = 0; fm < 7; fm++) begin
      if (fm == 0) tag = "R8"; else tag = "R9";
      wr(3'd4, 16'(fm));
      for (int b = 0; b < 4; b++) begin
        wr(3'd0, 16'(b));
        repeat (40) cyc(0, 0);
      end
    end
    wr(3'd3, 16'd0);
    wr(3'd0, 16'd1);
    gen = 0;

    tag = "R4/R10";
    for (int k = 0; k < 60; k++) cyc((k % 3) != 0, 0);
    for (int k = 0; k < 40; k++) cyc((k % 5) == 2 || (k % 5) == 4, 0);

    tag = "R6";
    for (int d = 0; d < 8; d++) begin
      wr(3'd2, 16'(d));
      for (int f = 0; f < 6; f++)
        for (int sl = 0; sl < 8; sl++) cyc(sl != 0, 0);
    end

    tag = "R5";
    wr(3'd1, 16'd1);
    for (int d = 0; d < 3; d++) begin
      wr(3'd2, 16'(d * 2));
      for (int k = 0; k < 48; k++) cyc((k % 4) != 0, 0);
    end
    wr(3'd1, 16'd0);
    repeat (6) cyc(1, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule